// File: doc/BRIEF.md
# Video Refill FIFO with Programmable Preload

This block buffers video data between a memory bus and a display pipeline. A memory controller writes words in the bus clock domain. It writes one 32-bit word per acknowledged cycle in narrow mode, or two words per cycle in wide mode. The display side pulls one word per read strobe in the pixel clock domain. The store holds 32 words of 32 bits. Read and write pointers cross between the two clocks as gray codes through two-flop synchronisers.

The block generates an active-low refill request towards the memory controller. A vertical flyback pulse empties the store. When flyback ends, a frame starts and the request is raised. The request stays raised until the buffered word count reaches a programmable preload level, and it is raised again whenever the count falls below that level. The level is four times a 3-bit setting. In wide mode an odd setting is rounded up, because memory delivers 8-word bursts. A setting of zero disables the request. Writes into a full store and reads from an empty one are dropped and raise sticky error flags.

Top module: `vrefill_fifo`

## Requirements
- R1: Words leave through `rd_data` in the order they were written, and each value appears one pixel clock after the edge that samples `pix_rd` high.
- R2: With `wide_bus` high, each accepted write stores `wr_data[31:0]` first and `wr_data[63:32]` second. With it low, only `wr_data[31:0]` is stored. A write is offered when `dack_n` is low and `flyback` is low.
- R3: The preload level in words is 4 × `preload_n`. When `wide_bus` is high and `preload_n` is odd, the level is 4 × (`preload_n` + 1).
- R4: After a frame start (the falling edge of `flyback`), `vid_req_n` is low exactly when the write-side word count, as seen two bus clocks earlier, is below the preload level. A burst that brings the count to the level stops the request, and reading the count below the level raises it again.
- R5: When `preload_n` is 0, `vid_req_n` stays high for the whole frame and nothing is requested.
- R6: While `flyback` is high, both pointers return to empty and `vid_req_n` is high. Words written before flyback cannot be read after it.
- R7: A write for which fewer slots are free than words offered is dropped entirely and sets `ovf_flag`. The flag holds until the next flyback.
- R8: A read strobe while the store is empty returns 0 on `rd_data` and sets `unf_flag`. The flag holds until the next flyback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Memory-side clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| pix_clk | input | 1 | Display-side clock |
| pix_rst_n | input | 1 | Synchronous active-low reset, pixel domain |
| flyback | input | 1 | Vertical flyback, bus domain; high flushes, falling edge starts a frame |
| wide_bus | input | 1 | 1: two words per write, 0: one word; changed only during flyback |
| preload_n | input | 3 | Preload setting (control register bits 10:8), changed only during flyback |
| dack_n | input | 1 | Active-low write strobe from the memory controller |
| wr_data | input | 64 | Write data, low word first |
| vid_req_n | output | 1 | Active-low refill request |
| ovf_flag | output | 1 | Sticky dropped-write flag, bus domain |
| pix_rd | input | 1 | Read strobe, pixel domain |
| rd_data | output | 32 | Read data, registered |
| unf_flag | output | 1 | Sticky empty-read flag, pixel domain |

## Verification
On every cycle, assertions check the following. The occupancy seen on each side never exceeds the depth. The request output always follows the level comparison two bus clocks later. An empty read yields zero with the underflow flag set, and both error flags hold until a flush. The bench's sweep over every preload setting in both bus widths shows the rest. It shows the actual preload fill, the odd-setting round-up in wide mode, and the re-arm after the display drains one burst. It also shows the silence at setting zero, data order across pointer wraps, words dropped at overflow, and that a flush leaves nothing readable.

// File: rtl/vfifo_pkg.sv
// Shared constants and the preload-level decode for the video refill FIFO.
// Assumes a 3-bit preload setting and a level counted in 4-word steps.
package vfifo_pkg;
    localparam int PRE_W = 3;
    localparam int LVL_W = 6;

    // Level in words: 4*n, odd n rounded up to the next even value in wide mode.
    function automatic logic [LVL_W-1:0] preload_level(input logic [PRE_W-1:0] n,
                                                       input logic wide);
        logic [LVL_W-3:0] m;
        m = {1'b0, n};
        if (wide && n[0]) m = m + 1'b1;
        return {m, 2'b00};
    endfunction
endpackage

// File: rtl/vfifo_sync.sv
// Two-flop synchroniser for a bus of bits into the clock domain of clk.
// Assumes multi-bit inputs are gray coded, so at most one bit moves at a time.
module vfifo_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages; both clear on synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/vfifo_ram.sv
// Word store with two write lanes (lane 1 writes the slot after lane 0) and
// one asynchronous read port. Assumes DEPTH is a power of two.
module vfifo_ram #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we0,
    input  logic          we1,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wd0,
    input  logic [DW-1:0] wd1,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rd
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] waddr_nx;

    assign waddr_nx = waddr + 1'b1;

    // Write one or two consecutive slots per clock.
    always_ff @(posedge clk) begin
        if (we0) mem[waddr]    <= wd0;
        if (we1) mem[waddr_nx] <= wd1;
    end

    assign rd = mem[raddr];
endmodule

// File: rtl/vfifo_req.sv
// Refill request generator, bus domain. Arms on the falling edge of flyback,
// compares the write-side count with the preload level, and delays the
// result by two registers before driving the active-low output.
// Assumes preload setting and width mode are static outside flyback.
module vfifo_req #(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flyback,
    input  logic [2:0]    n,
    input  logic          wide,
    input  logic [PW-1:0] count,
    output logic          req_n
);
    import vfifo_pkg::*;

    logic [PW-1:0] level;
    logic          fb_d, armed, raw, stg1, stg2;

    assign level = PW'(preload_level(n, wide));
    assign raw   = armed && (n != 3'd0) && (count < level);
    assign req_n = ~stg2;

    // Track flyback and arm the request on its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_d  <= 1'b0;
            armed <= 1'b0;
        end else begin
            fb_d <= flyback;
            if (flyback)   armed <= 1'b0;
            else if (fb_d) armed <= 1'b1;
        end
    end

    // Two-stage delay of the level compare toward the output pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1 <= 1'b0;
            stg2 <= 1'b0;
        end else begin
            stg1 <= raw;
            stg2 <= stg1;
        end
    end

    // R4
    req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_n |-> $past(raw, 2));
endmodule

// File: rtl/vrefill_fifo.sv
// Dual-clock video refill FIFO. The bus side writes one or two words per
// acknowledged cycle and raises a refill request below the preload level.
// The pixel side reads one word per strobe. Assumes: flyback is held for
// several cycles of both clocks, the display does not read during flyback,
// and wide_bus / preload_n change only during flyback.
module vrefill_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic                bus_clk,
    input  logic                bus_rst_n,
    input  logic                pix_clk,
    input  logic                pix_rst_n,
    input  logic                flyback,
    input  logic                wide_bus,
    input  logic [2:0]          preload_n,
    input  logic                dack_n,
    input  logic [2*DATA_W-1:0] wr_data,
    output logic                vid_req_n,
    output logic                ovf_flag,
    input  logic                pix_rd,
    output logic [DATA_W-1:0]   rd_data,
    output logic                unf_flag
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW:0] DEPTH_V = (PW+1)'(DEPTH);

    function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // ---------------- bus domain ----------------
    logic [PW-1:0] wptr, wgray_q, rgray_sync, rptr_seen, wcount;
    logic [PW:0]   need;
    logic          wr_try, wr_fit, we0;

    assign rptr_seen = gray2bin(rgray_sync);
    assign wcount    = wptr - rptr_seen;
    assign wr_try    = !dack_n && !flyback;
    assign need      = {1'b0, wcount} + (wide_bus ? (PW+1)'(2) : (PW+1)'(1));
    assign wr_fit    = need <= DEPTH_V;
    assign we0       = wr_try && wr_fit;

    // Advance the write pointer on accepted writes; flag dropped ones.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n || flyback) begin
            wptr     <= '0;
            ovf_flag <= 1'b0;
        end else if (wr_try) begin
            if (wr_fit) wptr <= wptr + (wide_bus ? PW'(2) : PW'(1));
            else        ovf_flag <= 1'b1;
        end
    end

    // Register the crossing code; wide mode encodes pairs so one bit moves per step.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) wgray_q <= '0;
        else            wgray_q <= bin2gray(wide_bus ? {1'b0, wptr[PW-1:1]} : wptr);
    end

    vfifo_sync #(.W(PW)) u_rptr_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(rgray_q), .q(rgray_sync)
    );

    vfifo_req #(.PW(PW)) u_req (
        .clk(bus_clk), .rst_n(bus_rst_n), .flyback(flyback), .n(preload_n),
        .wide(wide_bus), .count(wcount), .req_n(vid_req_n)
    );

    // ---------------- storage ----------------
    logic [PW-1:0]     rptr;
    logic [DATA_W-1:0] ram_rd;

    vfifo_ram #(.DW(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk(bus_clk), .we0(we0), .we1(we0 && wide_bus), .waddr(wptr[AW-1:0]),
        .wd0(wr_data[DATA_W-1:0]), .wd1(wr_data[2*DATA_W-1:DATA_W]),
        .raddr(rptr[AW-1:0]), .rd(ram_rd)
    );

    // ---------------- pixel domain ----------------
    logic [PW-1:0] rgray_q, wgray_sync, wdec, wptr_seen, rcount;
    logic          flush_p, empty;

    vfifo_sync #(.W(1)) u_flush_sync (
        .clk(pix_clk), .rst_n(pix_rst_n), .d(flyback), .q(flush_p)
    );

    vfifo_sync #(.W(PW)) u_wptr_sync (
        .clk(pix_clk), .rst_n(pix_rst_n), .d(wgray_q), .q(wgray_sync)
    );

    assign wdec      = gray2bin(wgray_sync);
    assign wptr_seen = wide_bus ? {wdec[PW-2:0], 1'b0} : wdec;
    assign rcount    = wptr_seen - rptr;
    assign empty     = (rcount == '0);

    // Serve read strobes; an empty read returns zero and flags underflow.
    always_ff @(posedge pix_clk) begin
        if (!pix_rst_n || flush_p) begin
            rptr     <= '0;
            rd_data  <= '0;
            unf_flag <= 1'b0;
        end else if (pix_rd) begin
            if (empty) begin
                rd_data  <= '0;
                unf_flag <= 1'b1;
            end else begin
                rd_data <= ram_rd;
                rptr    <= rptr + 1'b1;
            end
        end
    end

    // Publish the read pointer as gray code for the bus side.
    always_ff @(posedge pix_clk) begin
        if (!pix_rst_n) rgray_q <= '0;
        else            rgray_q <= bin2gray(rptr);
    end

    // R7
    bus_count_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n || flyback)
        {1'b0, wcount} <= DEPTH_V);
    // R7
    ovf_sticky_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (ovf_flag && !flyback) |=> ovf_flag);
    // R8
    pix_count_chk: assert property (@(posedge pix_clk) disable iff (!pix_rst_n || flush_p)
        {1'b0, rcount} <= DEPTH_V);
    // R8
    empty_read_chk: assert property (@(posedge pix_clk) disable iff (!pix_rst_n || flush_p)
        (pix_rd && empty) |=> (rd_data == '0 && unf_flag));
    // R8
    unf_sticky_chk: assert property (@(posedge pix_clk) disable iff (!pix_rst_n)
        (unf_flag && !flush_p) |=> unf_flag);
endmodule

// File: tb/vrefill_fifo_bench.sv
module vrefill_fifo_bench;
    localparam logic [31:0] BASE = 32'hC0DE_0000;

    logic        bus_clk = 1'b0, pix_clk = 1'b0;
    logic        bus_rst_n = 1'b0, pix_rst_n = 1'b0;
    logic        flyback = 1'b1, wide_bus = 1'b0;
    logic [2:0]  preload_n = 3'd0;
    logic        dack_n, vid_req_n, ovf_flag, pix_rd = 1'b0, unf_flag;
    logic [63:0] wr_data;
    logic [31:0] rd_data;

    logic        mem_en = 1'b0, m_ack_n = 1'b1, man_ack_n = 1'b1;
    logic [63:0] m_data = '0, man_data = '0;
    int          m_idx = 0, beats = 0, gap = 0, req_low_cnt = 0, cyc = 0;
    int          checks = 0, failures = 0;

    always #5 bus_clk = ~bus_clk;
    always #7 pix_clk = ~pix_clk;

    assign dack_n  = mem_en ? m_ack_n : man_ack_n;
    assign wr_data = mem_en ? m_data : man_data;

    vrefill_fifo u_vrefill_fifo (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .pix_clk(pix_clk), .pix_rst_n(pix_rst_n),
        .flyback(flyback), .wide_bus(wide_bus), .preload_n(preload_n), .dack_n(dack_n),
        .wr_data(wr_data), .vid_req_n(vid_req_n), .ovf_flag(ovf_flag), .pix_rd(pix_rd),
        .rd_data(rd_data), .unf_flag(unf_flag)
    );

    function automatic logic [63:0] mk(input int idx, input logic w);
        return w ? {BASE + 32'(idx + 1), BASE + 32'(idx)} : {32'h0, BASE + 32'(idx)};
    endfunction

    // Memory model: on a request, deliver one 4-beat burst, then pause.
    always @(negedge bus_clk) begin
        if (flyback) m_idx <= 0;
        if (!mem_en) begin
            m_ack_n <= 1'b1; beats <= 0; gap <= 0;
        end else if (beats != 0) begin
            m_ack_n <= 1'b0; m_data <= mk(m_idx, wide_bus);
            m_idx <= m_idx + (wide_bus ? 2 : 1); beats <= beats - 1;
        end else if (gap != 0) begin
            m_ack_n <= 1'b1; gap <= gap - 1;
        end else if (!vid_req_n) begin
            m_ack_n <= 1'b0; m_data <= mk(m_idx, wide_bus);
            m_idx <= m_idx + (wide_bus ? 2 : 1); beats <= 3; gap <= 4;
        end else begin
            m_ack_n <= 1'b1;
        end
    end

    always @(negedge bus_clk) if (bus_rst_n && !vid_req_n) req_low_cnt <= req_low_cnt + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pread(output logic [31:0] v);
        @(negedge pix_clk) pix_rd = 1'b1;
        @(negedge pix_clk) pix_rd = 1'b0;
        v = rd_data;
    endtask

    task automatic man_write(input int cnt, input int first);
        for (int i = 0; i < cnt; i++) begin
            @(negedge bus_clk);
            man_ack_n = 1'b0;
            man_data  = {32'h0, BASE + 32'(first + i)};
        end
        @(negedge bus_clk) man_ack_n = 1'b1;
    endtask

    task automatic frame_start(input logic w, input int n);
        mem_en = 1'b0;
        @(negedge bus_clk);
        flyback = 1'b1; wide_bus = w; preload_n = 3'(n);
        repeat (12) @(negedge bus_clk);
        chk(ovf_flag == 1'b0, "R7 ovf cleared by flyback", 32'(ovf_flag), 0);
        chk(unf_flag == 1'b0, "R8 unf cleared by flyback", 32'(unf_flag), 0);
        chk(vid_req_n == 1'b1, "R6 no request in flyback", 32'(vid_req_n), 1);
        flyback = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge bus_clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int lvl, k, base_req;
        repeat (5) @(negedge bus_clk);
        chk(vid_req_n == 1'b1, "R6 reset request idle", 32'(vid_req_n), 1);
        chk(rd_data == 32'h0, "R8 reset read data", rd_data, 0);
        bus_rst_n = 1'b1; pix_rst_n = 1'b1;

        // Overflow, ordering, underflow and flush in narrow mode.
        frame_start(1'b0, 0);
        man_write(34, 0);
        repeat (3) @(negedge bus_clk);
        chk(ovf_flag == 1'b1, "R7 overflow flagged", 32'(ovf_flag), 1);
        repeat (10) @(negedge pix_clk);
        for (int i = 0; i < 32; i++) begin
            pread(v);
            chk(v == BASE + 32'(i), "R1 R7 order, extra words dropped", v, BASE + 32'(i));
        end
        pread(v);
        chk(v == 32'h0, "R8 empty read gives zero", v, 0);
        chk(unf_flag == 1'b1, "R8 underflow flagged", 32'(unf_flag), 1);
        man_write(4, 100);
        repeat (10) @(negedge pix_clk);
        frame_start(1'b0, 0);
        repeat (10) @(negedge pix_clk);
        pread(v);
        chk(v == 32'h0, "R6 flush leaves nothing readable", v, 0);

        // Sweep all preload settings in both widths.
        for (int w = 0; w < 2; w++) begin
            for (int n = 0; n < 8; n++) begin
                lvl = (w == 1 && (n % 2) == 1) ? 4 * (n + 1) : 4 * n;
                k   = (w == 1) ? 8 : 4;
                frame_start(w[0], n);
                base_req = req_low_cnt;
                mem_en = 1'b1;
                repeat (120) @(negedge bus_clk);
                chk(m_idx == lvl, "R3 R4 preload fill level", 32'(m_idx), 32'(lvl));
                chk(vid_req_n == 1'b1, "R4 request drops at level", 32'(vid_req_n), 1);
                if (n == 0) begin
                    chk(req_low_cnt == base_req, "R5 zero setting never requests",
                        32'(req_low_cnt - base_req), 0);
                end else begin
                    mem_en = 1'b0;
                    repeat (10) @(negedge pix_clk);
                    for (int i = 0; i < k; i++) begin
                        pread(v);
                        chk(v == BASE + 32'(i), "R1 R2 word order", v, BASE + 32'(i));
                    end
                    repeat (10) @(negedge bus_clk);
                    mem_en = 1'b1;
                    repeat (40) @(negedge bus_clk);
                    chk(m_idx == lvl + k, "R4 re-request below level", 32'(m_idx), 32'(lvl + k));
                    chk(vid_req_n == 1'b1, "R4 refill stops at level", 32'(vid_req_n), 1);
                    mem_en = 1'b0;
                    repeat (10) @(negedge pix_clk);
                    for (int i = 0; i < lvl; i++) begin
                        pread(v);
                        chk(v == BASE + 32'(k + i), "R1 R2 drain order", v, BASE + 32'(k + i));
                    end
                    pread(v);
                    chk(v == 32'h0, "R8 empty after drain", v, 0);
                    chk(unf_flag == 1'b1, "R8 underflow after drain", 32'(unf_flag), 1);
                    chk(ovf_flag == 1'b0, "R7 no overflow in sweep", 32'(ovf_flag), 0);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule